// File: doc/BRIEF.md
# Z80 I/O Wait-State Responder

This block lets a slow local agent answer Z80 IN and OUT instructions aimed at a sixteen-port window. The window is selected when address bits 7..4 equal 1000 (ports 0x80 to 0x8F), so the CPU is free to put command codes in bits 3..0 and 15..8. When IORQ# goes low with a window address, a pending latch sets. WAIT# is driven low from that latch and stalls the CPU. Every CPU-side input first passes through a two-flop synchroniser.

Once the latch has held for two clocks, the block captures the 16-bit port address, the direction and the write byte. It hands them to the agent over a valid/ready request channel. The agent answers on a valid/ready response channel with a reply byte and a flag that asks for bus ownership.

- For an IN, the block drives the reply byte, raises BUSREQ#, and only then clears the latch to free WAIT#. It keeps driving the byte until BUSACK# arrives.
- For an OUT that asks for the bus, it raises BUSREQ#, clears the latch, waits for BUSACK#, pulses dma_start and waits for dma_done. It then drops the clear before BUSREQ#.
- For a plain OUT, it clears the latch and keeps the clear applied until IORQ# has gone high, so the same I/O cycle cannot retrigger the latch.

A watchdog ends a stalled handshake and raises an error flag.

Top module: `z80_io_responder`

## Requirements
- R1: The latch sets and WAIT# (z_wait_n) goes low only when IORQ# is low and address bits 7..4 are 1000. An address such as 0x0090 or 0x0070 leaves WAIT# high and req_valid low.
- R2: A captured request shows the 16-bit address on req_addr. req_is_in is 1 when RD# is low (IN) and 0 for a write (OUT), and req_wdata holds the byte on the data bus. req_valid stays high, with req_addr and req_is_in unchanged, until req_ready is high.
- R3: For an IN, z_data_out carries rsp_data and z_data_oe goes high in the same cycle that BUSREQ# goes low. This happens before WAIT# is released. z_data_oe stays high until the synchronised BUSACK# is low, then falls.
- R4: For a response with rsp_dma=1, BUSREQ# goes low before WAIT# is released. After BUSACK# is low, dma_start is high for exactly one cycle. BUSREQ# stays low until dma_done is seen high.
- R5: After a bus-acquired cycle, the internal clear is removed before BUSREQ# returns high. A new window cycle is accepted right after BUSREQ# is released.
- R6: For an OUT with rsp_dma=0, BUSREQ# stays high and WAIT# is released. WAIT# stays high while IORQ# remains low with a window address. It also stays high after IORQ# rises, and the next window cycle sets it low again.
- R7: If BUSACK# does not arrive within WD_CYCLES clocks, wd_error goes to 1, z_data_oe goes to 0 and BUSREQ# returns high. The same applies if IORQ# does not rise within WD_CYCLES clocks. wd_error returns to 0 when the next request is captured.
- R8: After reset, z_wait_n=1, z_busreq_n=1, z_data_oe=0, req_valid=0, dma_start=0 and wd_error=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| z_addr | input | 16 | CPU address bus |
| z_data_in | input | 8 | CPU data bus as seen by the block |
| z_data_out | output | 8 | Reply byte for IN cycles |
| z_data_oe | output | 1 | Enable for the data bus driver |
| z_iorq_n | input | 1 | CPU I/O request, active low |
| z_rd_n | input | 1 | CPU read strobe, active low |
| z_wr_n | input | 1 | CPU write strobe, active low |
| z_wait_n | output | 1 | Wait request to the CPU, active low |
| z_busreq_n | output | 1 | Bus request to the CPU, active low |
| z_busack_n | input | 1 | Bus grant from the CPU, active low |
| req_valid | output | 1 | Captured request is valid |
| req_ready | input | 1 | Agent accepts the request |
| req_addr | output | 16 | Captured port address |
| req_is_in | output | 1 | 1 for IN, 0 for OUT |
| req_wdata | output | 8 | Captured write byte |
| rsp_valid | input | 1 | Agent response is valid |
| rsp_ready | output | 1 | Block accepts the response |
| rsp_data | input | 8 | Reply byte for an IN |
| rsp_dma | input | 1 | Acquire the bus and run a transfer window |
| dma_start | output | 1 | One-cycle start of the transfer window |
| dma_done | input | 1 | Transfer window finished |
| wd_error | output | 1 | Watchdog expired during the last handshake |

## Verification
The main function is tried with four kinds of window cycle:
- An IN without a transfer, which shows that the reply is driven and the bus requested before WAIT# is freed.
- An OUT with a transfer and a stalled request channel, which separates the bus-acquired path and request holding from the plain path.
- A plain OUT with IORQ# held low long after release, which shows that the latch cannot retrigger on its own cycle.
- A back-to-back window cycle, which shows that the clear was indeed removed.

Addresses just above and just below the window check that the decode does not respond to them. A cycle whose bus grant never comes checks the watchdog and shows that its error flag clears on the next request.

// File: rtl/z80_io_responder.sv
module z80_io_responder #(
  parameter int WD_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] z_addr,
  input  logic [7:0]  z_data_in,
  output logic [7:0]  z_data_out,
  output logic        z_data_oe,
  input  logic        z_iorq_n,
  input  logic        z_rd_n,
  input  logic        z_wr_n,
  output logic        z_wait_n,
  output logic        z_busreq_n,
  input  logic        z_busack_n,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [15:0] req_addr,
  output logic        req_is_in,
  output logic [7:0]  req_wdata,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [7:0]  rsp_data,
  input  logic        rsp_dma,
  output logic        dma_start,
  input  logic        dma_done,
  output logic        wd_error
);
  localparam int WDW = $clog2(WD_CYCLES + 1);
  localparam logic [WDW-1:0] WD_LAST = WDW'(WD_CYCLES - 1);

  typedef enum logic [3:0] {
    IDLE, SETTLE, REQ, RSP, BREQ, WACK, XFER, REL1, REL2, WIORQ
  } st_t;

  st_t st;
  logic [1:0] iorq_q, rd_q, wr_q, ack_q;
  logic [15:0] a_q1, a_s;
  logic [7:0] d_q1, d_s;
  logic iorq_s, rd_s, wr_s, busack_s;
  logic pend, clr, breq, oe, use_dma, stl;
  logic [WDW-1:0] wd;

  assign iorq_s = iorq_q[1];
  assign rd_s = rd_q[1];
  assign wr_s = wr_q[1];
  assign busack_s = ack_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      iorq_q <= '1; rd_q <= '1; wr_q <= '1; ack_q <= '1;
      a_q1 <= '0; a_s <= '0; d_q1 <= '0; d_s <= '0;
    end else begin
      iorq_q <= {iorq_q[0], z_iorq_n};
      rd_q <= {rd_q[0], z_rd_n};
      wr_q <= {wr_q[0], z_wr_n};
      ack_q <= {ack_q[0], z_busack_n};
      a_q1 <= z_addr; a_s <= a_q1;
      d_q1 <= z_data_in; d_s <= d_q1;
    end

  wire hit = !iorq_s && (a_s[7:4] == 4'h8);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend <= 1'b0;
    else if (clr) pend <= 1'b0;
    else if (hit) pend <= 1'b1;

  assign z_wait_n = ~pend;
  assign z_busreq_n = ~breq;
  assign z_data_oe = oe;
  assign rsp_ready = (st == RSP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; stl <= 1'b0; wd <= '0;
      req_valid <= 1'b0; req_addr <= '0; req_is_in <= 1'b0; req_wdata <= '0;
      z_data_out <= '0; oe <= 1'b0; breq <= 1'b0; clr <= 1'b0;
      use_dma <= 1'b0; dma_start <= 1'b0; wd_error <= 1'b0;
    end else begin
      dma_start <= 1'b0;
      case (st)
        IDLE: if (pend) begin st <= SETTLE; stl <= 1'b0; end
        SETTLE:
          if (!stl) stl <= 1'b1;
          else begin
            req_addr <= a_s;
            req_is_in <= !rd_s && wr_s;
            req_wdata <= d_s;
            req_valid <= 1'b1;
            wd_error <= 1'b0;
            st <= REQ;
          end
        REQ: if (req_ready) begin req_valid <= 1'b0; st <= RSP; end
        RSP:
          if (rsp_valid) begin
            use_dma <= rsp_dma;
            wd <= '0;
            if (req_is_in) begin z_data_out <= rsp_data; oe <= 1'b1; end
            if (req_is_in || rsp_dma) begin breq <= 1'b1; st <= BREQ; end
            else begin clr <= 1'b1; st <= WIORQ; end
          end
        BREQ: begin clr <= 1'b1; st <= WACK; end
        WACK:
          if (!busack_s) begin
            oe <= 1'b0;
            if (use_dma) begin dma_start <= 1'b1; st <= XFER; end
            else st <= REL1;
          end else if (wd == WD_LAST) begin
            oe <= 1'b0; wd_error <= 1'b1; st <= REL1;
          end else wd <= wd + 1'b1;
        XFER: if (dma_done) st <= REL1;
        REL1: begin clr <= 1'b0; st <= REL2; end
        REL2: begin breq <= 1'b0; st <= IDLE; end
        WIORQ:
          if (iorq_s) begin clr <= 1'b0; st <= IDLE; end
          else if (wd == WD_LAST) begin clr <= 1'b0; wd_error <= 1'b1; st <= IDLE; end
          else wd <= wd + 1'b1;
        default: st <= IDLE;
      endcase
    end
endmodule

module z80_io_responder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  a_hi,
  input logic        iorq_s,
  input logic        busack_s,
  input logic        wait_n,
  input logic        breq,
  input logic        clr,
  input logic        oe,
  input logic        use_dma,
  input logic        req_is_in,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] req_addr,
  input logic        dma_start,
  input logic        wd_error
);
  // R1
  window_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_n) |-> $past(a_hi == 4'h8 && !iorq_s));
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_is_in));
  // R3
  oe_only_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> req_is_in);
  // R3
  busreq_before_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr) && (req_is_in || use_dma) |-> breq);
  // R4
  start_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_start) |-> $past(!busack_s));
  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start);
  // R5
  clr_before_busreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(breq) |-> !clr);
  // R6
  clr_held_iorq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clr) |-> iorq_s || wd_error);
endmodule

bind z80_io_responder z80_io_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .a_hi(a_s[7:4]), .iorq_s(iorq_s),
  .busack_s(busack_s), .wait_n(z_wait_n), .breq(breq), .clr(clr), .oe(oe),
  .use_dma(use_dma), .req_is_in(req_is_in), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .dma_start(dma_start),
  .wd_error(wd_error)
);

// File: tb/z80_io_responder_tb.sv
module z80_io_responder_tb_top;
  localparam int WD = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] z_addr = '0;
  logic [7:0] z_data_in = '0, z_data_out, rsp_data = '0, req_wdata;
  logic z_data_oe, z_wait_n, z_busreq_n;
  logic z_iorq_n = 1'b1, z_rd_n = 1'b1, z_wr_n = 1'b1, z_busack_n = 1'b1;
  logic req_valid, req_ready = 1'b1, req_is_in, rsp_valid = 1'b0, rsp_ready;
  logic [15:0] req_addr;
  logic rsp_dma = 1'b0, dma_start, dma_done = 1'b0, wd_error;
  int checks = 0, fails = 0, starts = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  z80_io_responder #(.WD_CYCLES(WD)) dut_i (.*);

  always @(posedge clk) if (dma_start) starts++;

  task automatic tick(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_io(input logic [15:0] a, input logic is_in, input logic [7:0] d);
    z_addr = a; z_data_in = d; z_iorq_n = 1'b0;
    z_rd_n = !is_in; z_wr_n = is_in;
  endtask

  task automatic end_io();
    z_iorq_n = 1'b1; z_rd_n = 1'b1; z_wr_n = 1'b1;
  endtask

  task automatic wait_req();
    for (int i = 0; i < 30 && !req_valid; i++) tick();
  endtask

  task automatic respond(input logic [7:0] d, input logic dma);
    for (int i = 0; i < 30 && !rsp_ready; i++) tick();
    rsp_data = d; rsp_dma = dma; rsp_valid = 1'b1;
    tick();
    rsp_valid = 1'b0;
  endtask

  task automatic wait_release();
    for (int i = 0; i < 30 && !z_wait_n; i++) tick();
  endtask

  task automatic t_reset();
    chk("R8 wait_n", z_wait_n, 1); chk("R8 busreq_n", z_busreq_n, 1);
    chk("R8 oe", z_data_oe, 0); chk("R8 req_valid", req_valid, 0);
    chk("R8 dma_start", dma_start, 0); chk("R8 wd_error", wd_error, 0);
  endtask

  task automatic t_outside();
    start_io(16'h0090, 1'b0, 8'h11);
    repeat (12) tick();
    chk("R1 0x90 wait_n", z_wait_n, 1); chk("R1 0x90 req_valid", req_valid, 0);
    end_io(); tick();
    start_io(16'hAB70, 1'b1, 8'h00);
    repeat (12) tick();
    chk("R1 0x70 wait_n", z_wait_n, 1); chk("R1 0x70 req_valid", req_valid, 0);
    end_io(); repeat (4) tick();
  endtask

  task automatic t_in();
    starts = 0;
    start_io(16'h3A85, 1'b1, 8'h00);
    wait_req();
    chk("R1 wait_n low", z_wait_n, 0);
    chk("R2 addr", req_addr, 16'h3A85); chk("R2 is_in", req_is_in, 1);
    respond(8'hC3, 1'b0);
    chk("R3 oe", z_data_oe, 1); chk("R3 data", z_data_out, 8'hC3);
    chk("R3 busreq_n", z_busreq_n, 0); chk("R3 still waiting", z_wait_n, 0);
    wait_release();
    chk("R3 released", z_wait_n, 1); chk("R3 busreq at release", z_busreq_n, 0);
    end_io(); repeat (3) tick();
    chk("R3 oe before ack", z_data_oe, 1);
    z_busack_n = 1'b0;
    for (int i = 0; i < 10 && z_data_oe; i++) tick();
    chk("R3 oe off after ack", z_data_oe, 0); chk("R3 busreq held", z_busreq_n, 0);
    for (int i = 0; i < 10 && !z_busreq_n; i++) tick();
    chk("R5 busreq released", z_busreq_n, 1);
    z_busack_n = 1'b1;
    start_io(16'h0081, 1'b0, 8'h00);
    for (int i = 0; i < 10 && z_wait_n; i++) tick();
    chk("R5 next cycle accepted", z_wait_n, 0);
    wait_req(); respond(8'h00, 1'b0); wait_release(); end_io(); repeat (6) tick();
    chk("R4 no dma_start on plain IN", starts, 0);
    chk("R7 no error", wd_error, 0);
  endtask

  task automatic t_out_dma();
    starts = 0;
    req_ready = 1'b0;
    start_io(16'h1287, 1'b0, 8'h5E);
    wait_req();
    repeat (3) tick();
    chk("R2 valid held", req_valid, 1); chk("R2 addr held", req_addr, 16'h1287);
    chk("R2 is_in out", req_is_in, 0); chk("R2 wdata", req_wdata, 8'h5E);
    req_ready = 1'b1; tick();
    chk("R2 valid drops", req_valid, 0);
    respond(8'h00, 1'b1);
    chk("R4 busreq_n", z_busreq_n, 0); chk("R4 no oe", z_data_oe, 0);
    chk("R4 still waiting", z_wait_n, 0);
    wait_release();
    end_io(); repeat (2) tick();
    chk("R4 no start before ack", starts, 0);
    z_busack_n = 1'b0;
    for (int i = 0; i < 10 && !dma_start; i++) tick();
    chk("R4 dma_start", dma_start, 1);
    tick();
    chk("R4 pulse one cycle", dma_start, 0);
    repeat (5) tick();
    chk("R4 busreq until done", z_busreq_n, 0);
    dma_done = 1'b1; tick(); dma_done = 1'b0;
    for (int i = 0; i < 10 && !z_busreq_n; i++) tick();
    chk("R5 busreq released", z_busreq_n, 1); chk("R4 start count", starts, 1);
    z_busack_n = 1'b1; repeat (4) tick();
  endtask

  task automatic t_out_plain();
    start_io(16'hFF8F, 1'b0, 8'hA0);
    wait_req();
    chk("R2 wdata plain", req_wdata, 8'hA0);
    respond(8'h00, 1'b0);
    chk("R6 no busreq", z_busreq_n, 1);
    wait_release();
    chk("R6 released", z_wait_n, 1);
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R6 no retrigger while IORQ low", z_wait_n, 1);
    end
    chk("R6 busreq idle", z_busreq_n, 1);
    end_io(); repeat (6) tick();
    chk("R6 after IORQ high", z_wait_n, 1);
    start_io(16'h0080, 1'b0, 8'h01);
    for (int i = 0; i < 10 && z_wait_n; i++) tick();
    chk("R6 next cycle accepted", z_wait_n, 0);
    wait_req(); respond(8'h00, 1'b0); wait_release(); end_io(); repeat (6) tick();
  endtask

  task automatic t_watchdog();
    start_io(16'h4484, 1'b1, 8'h00);
    wait_req(); respond(8'h77, 1'b0); wait_release(); end_io();
    for (int i = 0; i < WD + 20 && z_busreq_n == 1'b0; i++) tick();
    chk("R7 wd_error", wd_error, 1); chk("R7 oe off", z_data_oe, 0);
    chk("R7 busreq off", z_busreq_n, 1);
    repeat (3) tick();
    start_io(16'h0088, 1'b0, 8'h02);
    wait_req();
    chk("R7 error cleared", wd_error, 0);
    respond(8'h00, 1'b0); wait_release(); end_io(); repeat (6) tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_outside();
    t_in();
    t_out_dma();
    t_out_plain();
    t_watchdog();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule